// File: doc/BRIEF.md
# Register-Pair Immediate Adder

This execution unit carries out the word-add-immediate operation of a small 8-bit processor core. It takes a 16-bit instruction word and a one-cycle start pulse. From the word it extracts a 6-bit unsigned constant and one of four 16-bit register pairs at the top of a 32-entry by 8-bit register file. It then adds the constant to the pair over two clock cycles. The unit does not contain the register file. It drives one address into the file, reads that entry combinationally, and writes the new byte back on the same address. The low byte is handled in the first execution cycle and the high byte in the second.

The status byte is also outside the block. Its current value comes in on `sreg_i`. In the second execution cycle the unit presents an updated copy on `sreg_o` together with a write enable. Five flags are recomputed: sign, overflow, negative, zero and carry. The three upper bits pass through unchanged. Overflow and carry depend only on the old high-byte MSB and the new result MSB, because the constant is never negative.

Top module: `pairadd_unit`

## Requirements
- R1: A start pulse is accepted only when the unit is idle and `instr[15:8]` equals 0x96. The pair's low register is 24 + 2·`instr[5:4]` and its high register is the next entry up. The constant is {`instr[7:6]`, `instr[3:0]`}, in the range 0 to 63.
- R2: In the cycle after acceptance, `busy`=1, `done`=0 and `rf_we`=1. `rf_addr` is the low register and `rf_wdata` is (low byte + K) mod 256.
- R3: In the cycle after that, `busy`=1, `done`=1 and `rf_we`=1. `rf_addr` is the low register plus one and `rf_wdata` is the high byte plus the carry out of the low byte. The next cycle returns to idle with `busy`=0.
- R4: After completion the pair holds (old pair value + K) mod 65536. No other register is written.
- R5: Status bit 0 (carry) is 1 exactly when old value + K exceeds 0xFFFF.
- R6: Status bit 3 (overflow) is 1 exactly when old bit 15 is 0 and result bit 15 is 1. Carry and overflow are never both set.
- R7: Status bit 2 (negative) equals result bit 15. Bit 1 (zero) is 1 only when the full 16-bit result is 0x0000. Bit 4 (sign) equals negative XOR overflow.
- R8: `sreg_we` is high only in the second execution cycle. Status bits 7:5 on `sreg_o` equal those on `sreg_i`, so the half-carry flag is left unchanged. The status byte keeps its value through the first cycle.
- R9: A start pulse, with any instruction word, that arrives while `busy` is high has no effect.
- R10: A start pulse whose upper instruction byte is not 0x96 has no effect: `busy` and `rf_we` stay low.
- R11: While reset is active, `busy`, `done`, `rf_we` and `sreg_we` are 0.
- R12: 0xFFFF + 63 gives 0x003E with carry=1, zero=0, overflow=0. 0x7FFF + 1 gives 0x8000 with overflow=1 and negative=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute `instr` |
| instr | input | 16 | Instruction word |
| busy | output | 1 | High during both execution cycles |
| done | output | 1 | High during the second execution cycle |
| rf_addr | output | 5 | Register file read/write address |
| rf_rdata | input | 8 | Combinational read data at `rf_addr` |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 8 | Register file write data |
| sreg_i | input | 8 | Current status byte |
| sreg_we | output | 1 | Status byte write enable |
| sreg_o | output | 8 | Updated status byte |

## Verification
Two events can coincide in the second execution cycle. A new start pulse can arrive while the high byte is written back and the flags are committed, and the low-byte carry can ripple through the whole high byte in that same cycle. The bench holds start asserted with a different pair and constant throughout both execution cycles. It then checks that the target pair received exactly one addition and that the other pair stayed intact. A sweep over all four pairs and all 64 constants, with bases that sit on the 0x00FF, 0x7FFF and 0xFFFF boundaries, makes the carry into the high byte coincide with the flag update. The flags are judged against plain 17-bit arithmetic.

// File: rtl/pairadd_pkg.sv
package pairadd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2
   } pa_state_e;

   // status byte bit positions, decoded by the branch logic elsewhere
   localparam int FLAG_C = 0;
   localparam int FLAG_Z = 1;
   localparam int FLAG_N = 2;
   localparam int FLAG_V = 3;
   localparam int FLAG_S = 4;
   localparam int INSTR_W = 16;
   localparam int SREG_W  = 8;
endpackage

// File: rtl/pairadd_decode.sv
module pairadd_decode
   import pairadd_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          PAIR_BASE = 24,
   parameter int          IMM_W     = 6,
   parameter logic [7:0]  OPCODE    = 8'h96
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               match,
   output logic [ADDR_W-1:0]  pair_lo,
   output logic [IMM_W-1:0]   kval
);
   logic [1:0] sel;

   assign sel     = instr[5:4];
   assign match   = (instr[15:8] == OPCODE);
   assign pair_lo = ADDR_W'(PAIR_BASE + 2 * int'(sel));
   assign kval    = IMM_W'({instr[7:6], instr[3:0]});
endmodule

// File: rtl/pairadd_byte_add.sv
module pairadd_byte_add #(
   parameter int W     = 8,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (STYLE == 0) begin : g_infer
         logic [W:0] total;
         assign total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum   = total[W-1:0];
         assign cout  = total[W];
      end else begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ c[i];
            assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout = c[W];
      end
   endgenerate
endmodule

// File: rtl/pairadd_flags.sv
module pairadd_flags
   import pairadd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              old_msb,
   input  logic [DATA_W-1:0] hi_res,
   input  logic              lo_zero,
   input  logic [SREG_W-1:0] sreg_in,
   output logic [SREG_W-1:0] sreg_out
);
   localparam logic [SREG_W-1:0] KEEP = ~SREG_W'(8'h1F);

   logic new_msb, f_c, f_v, f_n, f_z, f_s;
   logic [SREG_W-1:0] fresh;

   assign new_msb = hi_res[DATA_W-1];
   assign f_c     = old_msb & ~new_msb;
   assign f_v     = ~old_msb & new_msb;
   assign f_n     = new_msb;
   assign f_z     = lo_zero & (hi_res == '0);
   assign f_s     = f_n ^ f_v;

   always_comb begin
      fresh         = '0;
      fresh[FLAG_C] = f_c;
      fresh[FLAG_Z] = f_z;
      fresh[FLAG_N] = f_n;
      fresh[FLAG_V] = f_v;
      fresh[FLAG_S] = f_s;
   end

   assign sreg_out = (sreg_in & KEEP) | fresh;
endmodule

// File: rtl/pairadd_unit.sv
module pairadd_unit
   import pairadd_pkg::*;
#(
   parameter int         DATA_W      = 8,
   parameter int         RF_DEPTH    = 32,
   parameter int         PAIR_BASE   = 24,
   parameter int         IMM_W       = 6,
   parameter logic [7:0] OPCODE      = 8'h96,
   parameter int         ADDER_STYLE = 0,
   localparam int        ADDR_W      = $clog2(RF_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [15:0]        instr,
   output logic               busy,
   output logic               done,
   output logic [ADDR_W-1:0]  rf_addr,
   input  logic [DATA_W-1:0]  rf_rdata,
   output logic               rf_we,
   output logic [DATA_W-1:0]  rf_wdata,
   input  logic [7:0]         sreg_i,
   output logic               sreg_we,
   output logic [7:0]         sreg_o
);
   // elaboration-time parameter checks
   generate
      if (IMM_W != 6) begin : g_bad_imm
         $error("pairadd_unit: IMM_W must be 6 to match the instruction format");
      end
      if (DATA_W < IMM_W) begin : g_bad_width
         $error("pairadd_unit: DATA_W must be at least IMM_W");
      end
      if ((PAIR_BASE % 2) != 0 || PAIR_BASE + 8 > RF_DEPTH) begin : g_bad_base
         $error("pairadd_unit: PAIR_BASE must be even and leave room for four pairs");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("pairadd_unit: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   pa_state_e             state_q, state_d;
   logic [ADDR_W-1:0]     base_q;
   logic [IMM_W-1:0]      k_q;
   logic                  carry_q;
   logic                  lo_zero_q;

   logic                  dec_match;
   logic [ADDR_W-1:0]     dec_lo;
   logic [IMM_W-1:0]      dec_k;
   logic                  accept;

   logic [DATA_W-1:0]     add_b;
   logic                  add_cin;
   logic [DATA_W-1:0]     add_sum;
   logic                  add_cout;

   pairadd_decode #(
      .ADDR_W    (ADDR_W),
      .PAIR_BASE (PAIR_BASE),
      .IMM_W     (IMM_W),
      .OPCODE    (OPCODE)
   ) dec_i (
      .instr   (instr),
      .match   (dec_match),
      .pair_lo (dec_lo),
      .kval    (dec_k)
   );

   assign accept = start & dec_match & (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = ST_LO;
         ST_LO:   state_d = ST_HI;
         ST_HI:   state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   // one adder shared by both halves: constant in the first cycle, carry in the second
   assign add_b   = (state_q == ST_LO) ? {{(DATA_W-IMM_W){1'b0}}, k_q} : '0;
   assign add_cin = (state_q == ST_HI) ? carry_q : 1'b0;

   pairadd_byte_add #(
      .W     (DATA_W),
      .STYLE (ADDER_STYLE)
   ) add_i (
      .a    (rf_rdata),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout)
   );

   pairadd_flags #(
      .DATA_W (DATA_W)
   ) flg_i (
      .old_msb  (rf_rdata[DATA_W-1]),
      .hi_res   (add_sum),
      .lo_zero  (lo_zero_q),
      .sreg_in  (sreg_i),
      .sreg_out (sreg_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         base_q    <= ADDR_W'(PAIR_BASE);
         k_q       <= '0;
         carry_q   <= 1'b0;
         lo_zero_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            base_q <= dec_lo;
            k_q    <= dec_k;
         end
         if (state_q == ST_LO) begin
            carry_q   <= add_cout;
            lo_zero_q <= (add_sum == '0);
         end
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_HI);
   assign rf_we    = busy;
   assign rf_wdata = add_sum;
   assign rf_addr  = (state_q == ST_HI) ? base_q + ADDR_W'(1) : base_q;
   assign sreg_we  = done;
endmodule

// File: rtl/pairadd_unit_chk.sv
module pairadd_unit_chk
   import pairadd_pkg::*;
#(
   parameter int         ADDR_W    = 5,
   parameter int         PAIR_BASE = 24,
   parameter logic [7:0] OPCODE    = 8'h96
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [15:0]       instr,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] rf_addr,
   input logic              rf_we,
   input logic [7:0]        sreg_i,
   input logic              sreg_we,
   input logic [7:0]        sreg_o
);
   assert_pair_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(rf_addr) >= PAIR_BASE && int'(rf_addr) < PAIR_BASE + 8));

   assert_write_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> busy);

   assert_done_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_high_follows_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (done && rf_addr == $past(rf_addr) + ADDR_W'(1)));

   assert_no_vc_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sreg_we |-> !(sreg_o[FLAG_V] && sreg_o[FLAG_C]));

   assert_sign_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sreg_we |-> (sreg_o[FLAG_S] == (sreg_o[FLAG_N] ^ sreg_o[FLAG_V])));

   assert_flag_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sreg_we |-> done);

   assert_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sreg_we |-> (sreg_o[7:5] == sreg_i[7:5]));

   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   assert_start_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(start) && $past(instr[15:8]) == OPCODE));
endmodule

bind pairadd_unit pairadd_unit_chk #(
   .ADDR_W    (ADDR_W),
   .PAIR_BASE (PAIR_BASE),
   .OPCODE    (OPCODE)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .instr   (instr),
   .busy    (busy),
   .done    (done),
   .rf_addr (rf_addr),
   .rf_we   (rf_we),
   .sreg_i  (sreg_i),
   .sreg_we (sreg_we),
   .sreg_o  (sreg_o)
);

// File: tb/pairadd_unit_tb.sv
module pairadd_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic        busy, done, rf_we, sreg_we;
   logic [4:0]  rf_addr;
   logic [7:0]  rf_rdata, rf_wdata, sreg_o;

   // bench-side register file and status byte
   logic [7:0]  rf [32];
   logic [7:0]  sreg = 8'h00;
   logic        tb_we = 1'b0;
   logic [4:0]  tb_addr = '0;
   logic [7:0]  tb_data = '0;
   logic        tb_swe = 1'b0;
   logic [7:0]  tb_sdata = '0;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (rf_we) rf[rf_addr] <= rf_wdata;
      else if (tb_we) rf[tb_addr] <= tb_data;
      if (sreg_we) sreg <= sreg_o;
      else if (tb_swe) sreg <= tb_sdata;
   end

   assign rf_rdata = rf[rf_addr];

   pairadd_unit dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .instr    (instr),
      .busy     (busy),
      .done     (done),
      .rf_addr  (rf_addr),
      .rf_rdata (rf_rdata),
      .rf_we    (rf_we),
      .rf_wdata (rf_wdata),
      .sreg_i   (sreg),
      .sreg_we  (sreg_we),
      .sreg_o   (sreg_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic load(input int addr, input logic [7:0] val);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 5'(addr); tb_data = val;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   function automatic logic [15:0] mk_instr(input int p, input int k);
      logic [5:0] kk = 6'(k);
      return {8'h96, kk[5:4], 2'(p), kk[3:0]};
   endfunction

   // one operation; if clash=1, start stays high with another word while busy
   task automatic run_op(input int p, input int k, input logic [15:0] val,
                         input logic [7:0] s0, input bit clash);
      int lo = 24 + 2 * p;
      int other = 24 + 2 * ((p + 1) % 4);
      logic [16:0] full = {1'b0, val} + 17'(k);
      logic [15:0] res = full[15:0];
      logic ec = full[16];
      logic ev = (val < 16'h8000) && (res >= 16'h8000);
      logic en = res[15];
      logic ez = (res == 16'h0000);
      logic [7:0] es = {s0[7:5], en ^ ev, ev, en, ez, ec};
      logic [7:0] other_lo = 8'h5A ^ 8'(k);
      load(lo, val[7:0]);
      load(lo + 1, val[15:8]);
      load(lo - 1, 8'hC3);
      if (clash) load(other, other_lo);
      tb_swe = 1'b1; tb_sdata = s0;
      @(negedge clk);
      tb_swe = 1'b0;
      start = 1'b1; instr = mk_instr(p, k);
      @(negedge clk);
      if (clash) instr = mk_instr((p + 1) % 4, 63 - k);
      else start = 1'b0;
      check("R2 busy in first cycle", 32'(busy), 1);
      check("R2 done low in first cycle", 32'(done), 0);
      check("R1 low address", 32'(rf_addr), 32'(lo));
      check("R2 low write data", 32'(rf_wdata), 32'(8'(val[7:0] + 8'(k))));
      check("R8 status held in first cycle", 32'(sreg), 32'(s0));
      @(negedge clk);
      check("R3 done in second cycle", 32'({busy, done, rf_we, sreg_we}), 32'hF);
      check("R3 high address", 32'(rf_addr), 32'(lo + 1));
      @(negedge clk);
      start = 1'b0;
      check("R3 idle after second cycle", 32'(busy), 0);
      check("R4 pair result", 32'({rf[lo+1], rf[lo]}), 32'(res));
      check("R4 neighbour untouched", 32'(rf[lo-1]), 32'hC3);
      check("R5 carry flag", 32'(sreg[0]), 32'(ec));
      check("R6 overflow flag", 32'(sreg[3]), 32'(ev));
      check("R7 negative zero sign", 32'({sreg[4], sreg[2], sreg[1]}), 32'({en ^ ev, en, ez}));
      check("R8 upper bits kept", 32'(sreg[7:5]), 32'(s0[7:5]));
      if (clash) begin
         @(negedge clk);
         check("R9 start while busy ignored", 32'(busy), 0);
         check("R9 other pair untouched", 32'(rf[other]), 32'(other_lo));
      end
   endtask

   initial begin
      while (cycles < WATCHDOG) begin
         @(posedge clk);
         cycles++;
      end
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [15:0] bases [7];
      bases = '{16'h0000, 16'h00FF, 16'h7FFF, 16'hFFFF, 16'h8000, 16'h1234, 16'hFFC1};
      for (int i = 0; i < 32; i++) rf[i] = 8'(i * 7);
      repeat (3) @(negedge clk);
      check("R11 reset outputs", 32'({busy, done, rf_we, sreg_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 idle after reset", 32'(busy), 0);

      // R12 named corner cases
      run_op(3, 63, 16'hFFFF, 8'hA0, 1'b0);
      check("R12 wrap result", 32'({rf[31], rf[30]}), 32'h003E);
      check("R12 wrap flags C Z V", 32'({sreg[0], sreg[1], sreg[3]}), 32'b100);
      run_op(0, 1, 16'h7FFF, 8'h40, 1'b0);
      check("R12 signed flip result", 32'({rf[25], rf[24]}), 32'h8000);
      check("R12 signed flip V N", 32'({sreg[3], sreg[2]}), 32'b11);

      // R10: wrong opcode is ignored
      load(26, 8'h11);
      load(27, 8'h22);
      @(negedge clk);
      start = 1'b1; instr = 16'h9712;
      @(negedge clk);
      start = 1'b0;
      check("R10 wrong opcode no busy", 32'({busy, rf_we}), 0);
      @(negedge clk);
      check("R10 wrong opcode no write", 32'({rf[27], rf[26]}), 32'h2211);

      // R9: start held with another word during both cycles
      run_op(1, 5, 16'h00FF, 8'hE0, 1'b1);
      run_op(2, 63, 16'hFFC1, 8'h20, 1'b1);

      // sweep: every pair, every constant, boundary bases
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 64; k++)
            for (int b = 0; b < 7; b++)
               run_op(p, k, bases[b], 8'((p * 64 + k) << 5), 1'b0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule